// File: doc/BRIEF.md
# Conversion Result Register with Read Lock

This block takes finished results from an analog-to-digital converter core and places them in two byte-wide registers, a high byte and a low byte, that a byte-wide bus reads one at a time. When a result lands in these registers the block sets a conversion-complete flag. It also sets an interrupt flag if the interrupt enable was high in that same cycle.

A bus master that reads a 10-bit or 12-bit result takes two accesses. Reading the high byte arms a read lock, and reading the low byte releases it. While the lock is armed, an arriving result is discarded instead of overwriting the half-read pair. The block then tells the converter what to do next. Normally it asks for a fresh conversion with a one-cycle restart pulse. There is one exception: a single conversion whose compare check failed ends the run with a one-cycle stop pulse. In FIFO operation, a hold output tells the channel and result queues not to advance while the lock is armed.

Top module: `adc_result_lock`

## Requirements
- R1: A result strobe that is neither blocked nor compare-failed loads the result registers and sets the complete flag on the next clock edge. Results are right-justified. Mode code 2'b01 is 10-bit and puts bits 9:8 in the high byte. Mode codes 2'b10 and 2'b11 are 12-bit and put bits 11:8 in the high byte. The low byte always takes bits 7:0.
- R2: In 8-bit mode (mode code 2'b00), the high byte reads zero, the low byte takes bits 7:0, and reading the high byte never arms the lock.
- R3: In 10-bit and 12-bit modes, a high-byte read arms the lock and a low-byte read releases it. If both reads happen in the same cycle, the release wins.
- R4: A result that arrives while the lock is armed is discarded. Both result bytes keep their values, and the result does not set the complete flag.
- R5: A discarded result produces a one-cycle restart pulse in both single and continuous mode. The only exception is the case in R6.
- R6: A result strobe with compare enabled and the compare condition false, in single mode, produces a one-cycle stop pulse and no restart pulse. It does this whether or not the lock is armed, and it loads nothing.
- R7: A compare-failed result in continuous mode with the lock released loads nothing and produces neither pulse.
- R8: The interrupt flag is set only together with the complete flag, and only if interrupt enable is high in the cycle the result loads. It clears whenever the complete flag clears.
- R9: A low-byte read or a status/control write clears the complete flag. If a result loads in the same cycle, the set wins.
- R10: The FIFO hold output is high exactly when FIFO mode is selected and the lock is armed.
- R11: After reset, the result bytes, both flags, the lock, the hold output and both pulses are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| resValid | input | 1 | Converter result strobe |
| resData | input | RES_W | Right-justified result |
| modeSel | input | 2 | Resolution: 00 8-bit, 01 10-bit, 1x 12-bit |
| cmpEn | input | 1 | Compare function enabled |
| cmpTrue | input | 1 | Compare condition met for this result |
| contMode | input | 1 | Continuous conversions selected |
| intEn | input | 1 | Interrupt enable |
| ctrlWrite | input | 1 | Status/control register write strobe |
| rdHigh | input | 1 | High-byte read strobe |
| rdLow | input | 1 | Low-byte read strobe |
| fifoMode | input | 1 | FIFO operation selected |
| resHigh | output | 8 | High result byte |
| resLow | output | 8 | Low result byte |
| cocoFlag | output | 1 | Conversion-complete flag |
| irqOut | output | 1 | Interrupt flag |
| lockActive | output | 1 | Read lock armed |
| fifoHold | output | 1 | Hold channel and result queues |
| restartReq | output | 1 | One-cycle request for a new conversion |
| convStop | output | 1 | One-cycle stop of the conversion run |

## Verification
Results are presented in each of the three resolutions. Data values with distinct upper nibbles show whether the high-byte masking follows the mode. Results are sent with the lock both armed and released, crossed with single and continuous mode and with the compare check passing and failing. This shows the block separating the restart case, the stop case and the silent discard. Same-cycle collisions are also driven: a high-byte read together with a low-byte read, and a result load together with a flag clear. These collisions expose which action wins.

// File: rtl/adc_rl_pkg.sv
package adc_rl_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    RES8   = 2'b00,
    RES10  = 2'b01,
    RES12  = 2'b10,
    RES12X = 2'b11
  } resMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic     load;
    resMode_t mode;
  } dpCtl_t;
endpackage

// File: rtl/adc_rl_ctrl.sv
module adc_rl_ctrl
  import adc_rl_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     resValid,
  input  resMode_t mode,
  input  logic     cmpEn,
  input  logic     cmpTrue,
  input  logic     contMode,
  input  logic     intEn,
  input  logic     ctrlWrite,
  input  logic     rdHigh,
  input  logic     rdLow,
  output dpCtl_t   dpCtl,
  output logic     lockActive,
  output logic     cocoFlag,
  output logic     irqFlag,
  output logic     restartReq,
  output logic     convStop
);
  logic cmpFail, blocked, accept, singleFail, armLock;

  always_comb begin
    cmpFail    = cmpEn & ~cmpTrue;
    singleFail = cmpFail & ~contMode;
    blocked    = resValid & lockActive;
    accept     = resValid & ~lockActive & ~cmpFail;
    armLock    = rdHigh & (mode != RES8);
    dpCtl.load = accept;
    dpCtl.mode = mode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockActive <= 1'b0;
      cocoFlag   <= 1'b0;
      irqFlag    <= 1'b0;
      restartReq <= 1'b0;
      convStop   <= 1'b0;
    end else begin
      if (rdLow)        lockActive <= 1'b0;
      else if (armLock) lockActive <= 1'b1;

      if (accept) begin
        cocoFlag <= 1'b1;
        irqFlag  <= intEn;
      end else if (rdLow || ctrlWrite) begin
        cocoFlag <= 1'b0;
        irqFlag  <= 1'b0;
      end

      restartReq <= blocked & ~singleFail;
      convStop   <= resValid & singleFail;
    end
  end
endmodule

// File: rtl/adc_rl_data.sv
module adc_rl_data
  import adc_rl_pkg::*;
#(
  parameter int RES_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            dpCtl,
  input  logic [RES_W-1:0]  resData,
  output logic [BYTE_W-1:0] resHigh,
  output logic [BYTE_W-1:0] resLow
);
  logic [BYTE_W-1:0] hiRaw, hiNext;

  generate
    if (RES_W > BYTE_W) begin : g_wide
      localparam int HI_W = RES_W - BYTE_W;
      localparam logic [BYTE_W-1:0] MASK_FULL = BYTE_W'((1 << HI_W) - 1);
      localparam logic [BYTE_W-1:0] MASK_10 = BYTE_W'(3) & MASK_FULL;
      always_comb begin
        hiRaw = BYTE_W'(resData >> BYTE_W);
        case (dpCtl.mode)
          RES8:    hiNext = '0;
          RES10:   hiNext = hiRaw & MASK_10;
          default: hiNext = hiRaw & MASK_FULL;
        endcase
      end
    end else begin : g_narrow
      always_comb begin
        hiRaw  = '0;
        hiNext = hiRaw;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resHigh <= '0;
      resLow  <= '0;
    end else if (dpCtl.load) begin
      resHigh <= hiNext;
      resLow  <= resData[BYTE_W-1:0];
    end
  end
endmodule

// File: rtl/adc_result_lock.sv
module adc_result_lock
  import adc_rl_pkg::*;
#(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             resValid,
  input  logic [RES_W-1:0] resData,
  input  logic [1:0]       modeSel,
  input  logic             cmpEn,
  input  logic             cmpTrue,
  input  logic             contMode,
  input  logic             intEn,
  input  logic             ctrlWrite,
  input  logic             rdHigh,
  input  logic             rdLow,
  input  logic             fifoMode,
  output logic [7:0]       resHigh,
  output logic [7:0]       resLow,
  output logic             cocoFlag,
  output logic             irqOut,
  output logic             lockActive,
  output logic             fifoHold,
  output logic             restartReq,
  output logic             convStop
);
  dpCtl_t dpCtl;

  adc_rl_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .resValid   (resValid),
    .mode       (resMode_t'(modeSel)),
    .cmpEn      (cmpEn),
    .cmpTrue    (cmpTrue),
    .contMode   (contMode),
    .intEn      (intEn),
    .ctrlWrite  (ctrlWrite),
    .rdHigh     (rdHigh),
    .rdLow      (rdLow),
    .dpCtl      (dpCtl),
    .lockActive (lockActive),
    .cocoFlag   (cocoFlag),
    .irqFlag    (irqOut),
    .restartReq (restartReq),
    .convStop   (convStop)
  );

  adc_rl_data #(.RES_W(RES_W)) i_data (
    .clk     (clk),
    .rstN    (rstN),
    .dpCtl   (dpCtl),
    .resData (resData),
    .resHigh (resHigh),
    .resLow  (resLow)
  );

  assign fifoHold = fifoMode & lockActive;
endmodule

// File: rtl/adc_rl_checker.sv
module adc_rl_checker #(
  parameter int RES_W = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic             resValid,
  input logic [RES_W-1:0] resData,
  input logic [1:0]       modeSel,
  input logic             cmpEn,
  input logic             cmpTrue,
  input logic             contMode,
  input logic             rdHigh,
  input logic             rdLow,
  input logic             fifoMode,
  input logic [7:0]       resHigh,
  input logic [7:0]       resLow,
  input logic             cocoFlag,
  input logic             irqOut,
  input logic             lockActive,
  input logic             fifoHold,
  input logic             restartReq,
  input logic             convStop
);
  assert_load_R1: assert property (@(posedge clk) disable iff (!rstN)
    resValid && !lockActive && !(cmpEn && !cmpTrue) |=> cocoFlag && resLow == $past(resData[7:0]));

  assert_no_arm8_R2: assert property (@(posedge clk) disable iff (!rstN)
    !lockActive && modeSel == 2'b00 |=> !lockActive);

  assert_release_R3: assert property (@(posedge clk) disable iff (!rstN)
    rdLow |=> !lockActive);

  assert_keep_R4: assert property (@(posedge clk) disable iff (!rstN)
    resValid && lockActive |=> $stable(resHigh) && $stable(resLow));

  assert_restart_R5: assert property (@(posedge clk) disable iff (!rstN)
    resValid && lockActive && !(cmpEn && !cmpTrue && !contMode) |=> restartReq);

  assert_stop_R6: assert property (@(posedge clk) disable iff (!rstN)
    resValid && cmpEn && !cmpTrue && !contMode |=> convStop && !restartReq);

  assert_silent_R7: assert property (@(posedge clk) disable iff (!rstN)
    resValid && !lockActive && cmpEn && !cmpTrue && contMode |=> !restartReq && !convStop && $stable(resLow));

  assert_irq_R8: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> cocoFlag);

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    rdLow && !resValid |=> !cocoFlag);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    fifoHold |-> lockActive && fifoMode);
endmodule

bind adc_result_lock adc_rl_checker #(.RES_W(RES_W)) i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .resValid   (resValid),
  .resData    (resData),
  .modeSel    (modeSel),
  .cmpEn      (cmpEn),
  .cmpTrue    (cmpTrue),
  .contMode   (contMode),
  .rdHigh     (rdHigh),
  .rdLow      (rdLow),
  .fifoMode   (fifoMode),
  .resHigh    (resHigh),
  .resLow     (resLow),
  .cocoFlag   (cocoFlag),
  .irqOut     (irqOut),
  .lockActive (lockActive),
  .fifoHold   (fifoHold),
  .restartReq (restartReq),
  .convStop   (convStop)
);

// File: tb/test_adc_result_lock.sv
module test_adc_result_lock;
  logic clk = 1'b0, rstN = 1'b0;
  logic resValid = 0, cmpEn = 0, cmpTrue = 0, contMode = 0, intEn = 0;
  logic ctrlWrite = 0, rdHigh = 0, rdLow = 0, fifoMode = 0;
  logic [11:0] resData = '0;
  logic [1:0]  modeSel = 2'b10;
  logic [7:0]  resHigh, resLow;
  logic cocoFlag, irqOut, lockActive, fifoHold, restartReq, convStop;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] hi, lo;
    logic coco, irq, lock, hold, rst, stp;
    string tag;
  } exp_t;
  exp_t q[$];

  // reference state derived from the requirements
  logic [7:0] mHi = 0, mLo = 0;
  logic mCoco = 0, mIrq = 0, mLock = 0;

  always #4 clk = ~clk;

  adc_result_lock i_adc_result_lock (
    .clk(clk), .rstN(rstN), .resValid(resValid), .resData(resData),
    .modeSel(modeSel), .cmpEn(cmpEn), .cmpTrue(cmpTrue), .contMode(contMode),
    .intEn(intEn), .ctrlWrite(ctrlWrite), .rdHigh(rdHigh), .rdLow(rdLow),
    .fifoMode(fifoMode), .resHigh(resHigh), .resLow(resLow), .cocoFlag(cocoFlag),
    .irqOut(irqOut), .lockActive(lockActive), .fifoHold(fifoHold),
    .restartReq(restartReq), .convStop(convStop)
  );

  // driver: compute expectation for this edge, push it, advance one cycle
  task automatic tick(input string tag);
    exp_t e;
    logic fail, acc, blk;
    fail = cmpEn & ~cmpTrue;
    blk  = resValid & mLock;
    acc  = resValid & ~mLock & ~fail;
    e.rst = blk & ~(fail & ~contMode);
    e.stp = resValid & fail & ~contMode;
    if (acc) begin
      mLo = resData[7:0];
      case (modeSel)
        2'b00:   mHi = 8'h00;
        2'b01:   mHi = {6'b0, resData[9:8]};
        default: mHi = {4'b0, resData[11:8]};
      endcase
      mCoco = 1; mIrq = intEn;
    end else if (rdLow || ctrlWrite) begin
      mCoco = 0; mIrq = 0;
    end
    if (rdLow) mLock = 0;
    else if (rdHigh && modeSel != 2'b00) mLock = 1;
    e.hi = mHi; e.lo = mLo; e.coco = mCoco; e.irq = mIrq; e.lock = mLock;
    e.hold = fifoMode & mLock; e.tag = tag;
    q.push_back(e);
    @(posedge clk);
    @(negedge clk);
    resValid = 0; rdHigh = 0; rdLow = 0; ctrlWrite = 0;
  endtask

  // monitor: compare away from the edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (resHigh !== e.hi || resLow !== e.lo || cocoFlag !== e.coco || irqOut !== e.irq ||
            lockActive !== e.lock || fifoHold !== e.hold || restartReq !== e.rst || convStop !== e.stp) begin
          errors++;
          $display("FAIL %s: got hi=%h lo=%h coco=%b irq=%b lock=%b hold=%b rst=%b stp=%b exp hi=%h lo=%h coco=%b irq=%b lock=%b hold=%b rst=%b stp=%b",
                   e.tag, resHigh, resLow, cocoFlag, irqOut, lockActive, fifoHold, restartReq, convStop,
                   e.hi, e.lo, e.coco, e.irq, e.lock, e.hold, e.rst, e.stp);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    tick("R11 reset state");
    // 12-bit load with interrupt
    modeSel = 2'b10; intEn = 1; fifoMode = 1;
    resValid = 1; resData = 12'hABC; tick("R1 R8 12-bit load");
    rdHigh = 1; tick("R3 R10 arm lock");
    resValid = 1; resData = 12'h123; tick("R4 R5 blocked single");
    rdLow = 1; tick("R3 R9 release and clear");
    // 10-bit load without interrupt
    modeSel = 2'b01; intEn = 0;
    resValid = 1; resData = 12'hFFF; tick("R1 R8 10-bit load no irq");
    intEn = 1; tick("R8 late enable");
    ctrlWrite = 1; tick("R9 write clears");
    rdHigh = 1; rdLow = 1; tick("R3 same-cycle reads");
    rdHigh = 1; tick("R3 arm again");
    resValid = 1; resData = 12'h456; cmpEn = 1; cmpTrue = 0; contMode = 0;
    tick("R6 stop while locked");
    resValid = 1; resData = 12'h789; cmpEn = 0; contMode = 1;
    tick("R5 blocked continuous");
    rdLow = 1; tick("R3 release");
    // 8-bit
    modeSel = 2'b00; contMode = 0;
    resValid = 1; resData = 12'hF5A; tick("R2 8-bit load");
    rdHigh = 1; tick("R2 no arm");
    resValid = 1; resData = 12'h377; tick("R2 load not blocked");
    // compare cases
    modeSel = 2'b11; cmpEn = 1; cmpTrue = 0; contMode = 1;
    resValid = 1; resData = 12'hE01; tick("R7 continuous compare fail");
    cmpTrue = 1; resValid = 1; resData = 12'hD02; tick("R1 compare pass");
    cmpEn = 0; contMode = 0;
    resValid = 1; resData = 12'h534; rdLow = 1; tick("R9 set wins over read");
    resValid = 1; resData = 12'h2C8; ctrlWrite = 1; tick("R9 set wins over write");
    fifoMode = 0; rdHigh = 1; tick("R10 hold off without fifo");
    repeat (3) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule